// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block caches page table entries and turns 32-bit virtual addresses into physical addresses. Each of its `ENTRIES` slots pairs a tag part (virtual page number, address-space identifier, valid, global, page size) with a data part (physical frame number, cacheable, bufferable, dirty, write-through and a 3-bit permission code). All slots are compared against a lookup in parallel. The result comes back on a registered response port one cycle later, with the page offset merged in according to the matching slot's page size.

Software that manages the table loads a slot through the write port. It supplies the raw page table word, which is taken without reformatting, together with the tag fields. Each slot carries an accessed flag. A write sets the flag and a lookup hit clears it. The block offers the lowest-indexed flagged slot as the next victim, which gives a cheap pseudo-LRU choice for refills. Table walks, faults and permission enforcement are handled elsewhere.

Top module: `xlat_tlb`

## Requirements
- R1: While `rst` is high on a clock edge, every slot becomes invalid, every accessed flag becomes 1 and the response registers clear. After release, `rsp_valid` is 0, lookups miss and `victim_index` is 0.
- R2: `wr_en` at an edge loads slot `wr_index` from `wr_pte` and the tag inputs, and the slot is visible to lookups from the next cycle. The word layout is: frame number bits 31:10, cacheable bit 9, permission bits 8:6, page size bits 5:4, write-through bit 3, bufferable bit 2, global bit 1, dirty bit 0.
- R3: A slot matches when it is valid, its page number equals `lk_vaddr[31:10]` on the compared bits, and either its global bit is 1 or its stored identifier equals `lk_asid`.
- R4: Page size 00 is 1 KB, 01 is 4 KB, 10 is 64 KB and 11 is 1 MB. For these sizes the lowest 0, 2, 6 and 10 page-number bits are left out of the compare. Those bits of the physical address, and all of bits 9:0, come from `lk_vaddr`. The remaining bits come from the frame number.
- R5: A lookup with `lk_valid` high in cycle n gives `rsp_valid` high in cycle n+1 with its result. On a miss, `rsp_hit`, `rsp_index`, `rsp_paddr` and all attribute outputs are 0. A write in the same cycle does not affect that lookup's result.
- R6: When several slots match, the lowest-indexed one supplies the result and `rsp_multi` is 1. With one match, `rsp_multi` is 0.
- R7: A write sets the accessed flag of the written slot.
- R8: A hit clears the hit slot's accessed flag. If that would leave every flag at 0, all flags except the hit slot's are set to 1.
- R9: `victim_index` is the lowest slot index whose accessed flag is 1.
- R10: With `ISIDE`=0, `rsp_ap[0]` always reads 0. With `ISIDE`=1, `rsp_dirty`, `rsp_wthru` and `rsp_ap[1]` always read 0.
- R11: When a hit and a write fall on the same slot in one cycle, that slot's accessed flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space identifier |
| wr_en | input | 1 | Load one slot |
| wr_index | input | IDX_W | Slot to load |
| wr_pte | input | 32 | Page table word for the slot's data and size/global |
| wr_vpn | input | 22 | Virtual page number tag |
| wr_asid | input | 8 | Address-space identifier tag |
| wr_valid | input | 1 | Valid flag for the loaded slot |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup matched a slot |
| rsp_multi | output | 1 | More than one slot matched |
| rsp_index | output | IDX_W | Index of the supplying slot |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_cach | output | 1 | Cacheable attribute |
| rsp_bufr | output | 1 | Bufferable attribute |
| rsp_dirty | output | 1 | Dirty attribute |
| rsp_wthru | output | 1 | Write-through attribute |
| rsp_ap | output | 3 | Access permission code |
| victim_index | output | IDX_W | Suggested slot for the next refill |

## Verification
A corrupted tag shows up on the very next lookup response as a wrong hit, wrong index or wrong frame bits. A bad size mask shows up as wrong pass-through bits in `rsp_paddr`. Accessed-flag damage is invisible to lookups. It surfaces only on `victim_index`, in the cycle after the write or hit that updated the flags. For that reason the bench compares `victim_index` after every step against its own flag model, and drives the all-cleared refill and the same-slot hit-plus-write case directly.

// File: rtl/xlat_tlb_pkg.sv
package xlat_tlb_pkg;

  typedef struct packed {
    logic [21:0] vpn;
    logic [7:0]  asid;
    logic        vld;
    logic        glb;
    logic [1:0]  sz;
  } tag_t;

  typedef struct packed {
    logic [21:0] pfn;
    logic        cach;
    logic        bufr;
    logic        dirty;
    logic        wthru;
    logic [2:0]  ap;
  } dat_t;

  // page-number bits excluded from the compare for a given page size
  function automatic logic [21:0] low_mask(input logic [1:0] sz);
    case (sz)
      2'b00:   return 22'h000000;
      2'b01:   return 22'h000003;
      2'b10:   return 22'h00003F;
      default: return 22'h0003FF;
    endcase
  endfunction

endpackage

// File: rtl/xlat_tlb_store.sv
module xlat_tlb_store
  import xlat_tlb_pkg::*;
#(
  parameter int N     = 8,
  parameter bit ISIDE = 1'b0,
  parameter int IW    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IW-1:0]       wr_idx,
  input  logic [31:0]         wr_pte,
  input  logic [21:0]         wr_vpn,
  input  logic [7:0]          wr_asid,
  input  logic                wr_vld,
  input  logic [21:0]         lk_vpn,
  input  logic [7:0]          lk_asid,
  output logic [N-1:0]        match,
  output dat_t [N-1:0]        dat_o,
  output logic [N-1:0][1:0]   sz_o
);

  dat_t wr_dat;
  tag_t wr_tag;

  // variant: fields that a side has no use for are never stored
  generate
    if (ISIDE) begin : g_iside
      assign wr_dat = '{pfn: wr_pte[31:10], cach: wr_pte[9], bufr: wr_pte[2],
                        dirty: 1'b0, wthru: 1'b0,
                        ap: {wr_pte[8], 1'b0, wr_pte[6]}};
    end else begin : g_dside
      assign wr_dat = '{pfn: wr_pte[31:10], cach: wr_pte[9], bufr: wr_pte[2],
                        dirty: wr_pte[0], wthru: wr_pte[3],
                        ap: {wr_pte[8:7], 1'b0}};
    end
  endgenerate

  assign wr_tag = '{vpn: wr_vpn, asid: wr_asid, vld: wr_vld,
                    glb: wr_pte[1], sz: wr_pte[5:4]};

  for (genvar i = 0; i < N; i++) begin : g_ent
    tag_t tag_q;
    dat_t dat_q;
    logic sel;

    assign sel = wr_en && (wr_idx == IW'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        tag_q.vld <= 1'b0;
      end else if (sel) begin
        tag_q <= wr_tag;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) dat_q <= wr_dat;
    end

    assign match[i] = tag_q.vld
                    && (tag_q.glb || (tag_q.asid == lk_asid))
                    && (((tag_q.vpn ^ lk_vpn) & ~low_mask(tag_q.sz)) == 22'h0);
    assign dat_o[i] = dat_q;
    assign sz_o[i]  = tag_q.sz;
  end

endmodule

// File: rtl/xlat_tlb_pick.sv
module xlat_tlb_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  match,
  output logic          hit,
  output logic          multi,
  output logic [IW-1:0] idx
);

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end

  assign multi = ($countones(match) > 1);

endmodule

// File: rtl/xlat_tlb_age.sv
module xlat_tlb_age #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit_en,
  input  logic [IW-1:0] hit_idx,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  output logic [N-1:0]  acc_o,
  output logic [IW-1:0] victim_o
);

  logic [N-1:0] acc_q;
  logic [N-1:0] acc_d;

  always_comb begin
    acc_d = acc_q;
    if (hit_en) begin
      acc_d[hit_idx] = 1'b0;
      if (acc_d == '0) begin
        acc_d          = '1;
        acc_d[hit_idx] = 1'b0;
      end
    end
    if (wr_en) acc_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '1;
    else     acc_q <= acc_d;
  end

  always_comb begin
    victim_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (acc_q[i]) victim_o = IW'(i);
    end
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_tlb_pkg::*;
#(
  parameter int  ENTRIES = 8,
  parameter bit  ISIDE   = 1'b0,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [31:0]      lk_vaddr,
  input  logic [7:0]       lk_asid,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_index,
  input  logic [31:0]      wr_pte,
  input  logic [21:0]      wr_vpn,
  input  logic [7:0]       wr_asid,
  input  logic             wr_valid,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_multi,
  output logic [IDX_W-1:0] rsp_index,
  output logic [31:0]      rsp_paddr,
  output logic             rsp_cach,
  output logic             rsp_bufr,
  output logic             rsp_dirty,
  output logic             rsp_wthru,
  output logic [2:0]       rsp_ap,
  output logic [IDX_W-1:0] victim_index
);

  logic [ENTRIES-1:0]      match;
  dat_t [ENTRIES-1:0]      dat_all;
  logic [ENTRIES-1:0][1:0] sz_all;
  logic                    hit;
  logic                    multi;
  logic [IDX_W-1:0]        sel_idx;
  logic [ENTRIES-1:0]      acc_bits;
  dat_t                    sel_dat;
  logic [21:0]             sel_msk;
  logic [31:0]             paddr;

  xlat_tlb_store #(.N(ENTRIES), .ISIDE(ISIDE), .IW(IDX_W)) store_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_index),
    .wr_pte  (wr_pte),
    .wr_vpn  (wr_vpn),
    .wr_asid (wr_asid),
    .wr_vld  (wr_valid),
    .lk_vpn  (lk_vaddr[31:10]),
    .lk_asid (lk_asid),
    .match   (match),
    .dat_o   (dat_all),
    .sz_o    (sz_all)
  );

  xlat_tlb_pick #(.N(ENTRIES), .IW(IDX_W)) pick_i (
    .match (match),
    .hit   (hit),
    .multi (multi),
    .idx   (sel_idx)
  );

  xlat_tlb_age #(.N(ENTRIES), .IW(IDX_W)) age_i (
    .clk      (clk),
    .rst      (rst),
    .hit_en   (lk_valid && hit),
    .hit_idx  (sel_idx),
    .wr_en    (wr_en),
    .wr_idx   (wr_index),
    .acc_o    (acc_bits),
    .victim_o (victim_index)
  );

  assign sel_dat = dat_all[sel_idx];
  assign sel_msk = low_mask(sz_all[sel_idx]);
  assign paddr   = {(sel_dat.pfn & ~sel_msk) | (lk_vaddr[31:10] & sel_msk),
                    lk_vaddr[9:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_index <= '0;
      rsp_paddr <= '0;
      rsp_cach  <= 1'b0;
      rsp_bufr  <= 1'b0;
      rsp_dirty <= 1'b0;
      rsp_wthru <= 1'b0;
      rsp_ap    <= '0;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid && hit) begin
        rsp_hit   <= 1'b1;
        rsp_multi <= multi;
        rsp_index <= sel_idx;
        rsp_paddr <= paddr;
        rsp_cach  <= sel_dat.cach;
        rsp_bufr  <= sel_dat.bufr;
        rsp_dirty <= sel_dat.dirty;
        rsp_wthru <= sel_dat.wthru;
        rsp_ap    <= sel_dat.ap;
      end else begin
        rsp_hit   <= 1'b0;
        rsp_multi <= 1'b0;
        rsp_index <= '0;
        rsp_paddr <= '0;
        rsp_cach  <= 1'b0;
        rsp_bufr  <= 1'b0;
        rsp_dirty <= 1'b0;
        rsp_wthru <= 1'b0;
        rsp_ap    <= '0;
      end
    end
  end

endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          lk_valid,
  input logic [31:0]   lk_vaddr,
  input logic          wr_en,
  input logic [IW-1:0] wr_index,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic          rsp_multi,
  input logic [31:0]   rsp_paddr,
  input logic [N-1:0]  acc_bits,
  input logic [IW-1:0] victim_index
);

  AST_RESET_IDLE: assert property (@(posedge clk) $past(rst) |-> !rsp_valid); // R1

  AST_RSP_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(lk_valid)); // R5

  AST_HIT_IN_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid); // R5

  AST_MULTI_HAS_HIT: assert property (@(posedge clk) disable iff (rst)
    rsp_multi |-> rsp_hit); // R6

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (rsp_paddr[9:0] == $past(lk_vaddr[9:0]))); // R4

  AST_WRITE_MARKS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> acc_bits[$past(wr_index)]); // R7

  AST_ACC_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    acc_bits != '0); // R8

  AST_VICTIM_MARKED: assert property (@(posedge clk) disable iff (rst)
    acc_bits[victim_index]); // R9

endmodule

bind xlat_tlb xlat_tlb_chk #(.N(ENTRIES), .IW(IDX_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .lk_valid     (lk_valid),
  .lk_vaddr     (lk_vaddr),
  .wr_en        (wr_en),
  .wr_index     (wr_index),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .rsp_multi    (rsp_multi),
  .rsp_paddr    (rsp_paddr),
  .acc_bits     (acc_bits),
  .victim_index (victim_index)
);

// File: tb/xlat_tlb_tb_top.sv
module xlat_tlb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0] lk_asid = '0;
  logic wr_en = 1'b0;
  logic [IW-1:0] wr_index = '0;
  logic [31:0] wr_pte = '0;
  logic [21:0] wr_vpn = '0;
  logic [7:0] wr_asid = '0;
  logic wr_valid = 1'b0;

  logic rsp_valid, rsp_hit, rsp_multi, rsp_cach, rsp_bufr, rsp_dirty, rsp_wthru;
  logic [IW-1:0] rsp_index, victim_index;
  logic [31:0] rsp_paddr;
  logic [2:0] rsp_ap;
  logic i_valid, i_hit, i_multi, i_cach, i_bufr, i_dirty, i_wthru;
  logic [IW-1:0] i_index, i_victim;
  logic [31:0] i_paddr;
  logic [2:0] i_ap;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xlat_tlb #(.ENTRIES(NE), .ISIDE(1'b0)) dut_i (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
    .wr_en(wr_en), .wr_index(wr_index), .wr_pte(wr_pte), .wr_vpn(wr_vpn),
    .wr_asid(wr_asid), .wr_valid(wr_valid), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_multi(rsp_multi), .rsp_index(rsp_index), .rsp_paddr(rsp_paddr),
    .rsp_cach(rsp_cach), .rsp_bufr(rsp_bufr), .rsp_dirty(rsp_dirty),
    .rsp_wthru(rsp_wthru), .rsp_ap(rsp_ap), .victim_index(victim_index));

  xlat_tlb #(.ENTRIES(NE), .ISIDE(1'b1)) dut_isd (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
    .wr_en(wr_en), .wr_index(wr_index), .wr_pte(wr_pte), .wr_vpn(wr_vpn),
    .wr_asid(wr_asid), .wr_valid(wr_valid), .rsp_valid(i_valid), .rsp_hit(i_hit),
    .rsp_multi(i_multi), .rsp_index(i_index), .rsp_paddr(i_paddr),
    .rsp_cach(i_cach), .rsp_bufr(i_bufr), .rsp_dirty(i_dirty),
    .rsp_wthru(i_wthru), .rsp_ap(i_ap), .victim_index(i_victim));

  int n_run = 0;
  int n_fail = 0;

  // bench model
  logic [21:0] m_vpn [NE];
  logic [7:0]  m_asid [NE];
  logic        m_vld [NE];
  logic [31:0] m_pte [NE];
  logic [NE-1:0] m_acc;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [21:0] ign_mask(logic [1:0] sz);
    case (sz)
      2'b00: return 22'h0;
      2'b01: return 22'h3;
      2'b10: return 22'h3F;
      default: return 22'h3FF;
    endcase
  endfunction

  function automatic logic [31:0] mk_pte(logic [21:0] pfn, logic c, logic [2:0] ap,
      logic [1:0] sz, logic w, logic b, logic g, logic d);
    return {pfn, c, ap, sz, w, b, g, d};
  endfunction

  task automatic step(string vtag, logic do_lk, logic [31:0] va, logic [7:0] asid,
      logic do_wr, int widx, logic [31:0] pte, logic [21:0] vpn, logic [7:0] wasid,
      logic wval);
    logic e_hit;
    int e_idx, e_cnt;
    logic [31:0] e_pa, e_pte;
    logic [21:0] m;
    logic [NE-1:0] a;
    e_hit = 0; e_idx = 0; e_cnt = 0; e_pa = 0; e_pte = 0;
    for (int i = 0; i < NE; i++) begin
      m = ign_mask(m_pte[i][5:4]);
      if (m_vld[i] && (m_pte[i][1] || m_asid[i] == asid) &&
          (((m_vpn[i] ^ va[31:10]) & ~m) == 0)) begin
        if (!e_hit) begin
          e_hit = 1; e_idx = i; e_pte = m_pte[i];
          e_pa = {(m_pte[i][31:10] & ~m) | (va[31:10] & m), va[9:0]};
        end
        e_cnt++;
      end
    end
    if (!do_lk) begin e_hit = 0; e_cnt = 0; end
    lk_valid = do_lk; lk_vaddr = va; lk_asid = asid;
    wr_en = do_wr; wr_index = IW'(widx); wr_pte = pte; wr_vpn = vpn;
    wr_asid = wasid; wr_valid = wval;
    @(posedge clk);
    a = m_acc;
    if (e_hit) begin
      a[e_idx] = 0;
      if (a == 0) begin a = '1; a[e_idx] = 0; end
    end
    if (do_wr) begin
      a[widx] = 1;
      m_vpn[widx] = vpn; m_asid[widx] = wasid; m_vld[widx] = wval; m_pte[widx] = pte;
    end
    m_acc = a;
    @(negedge clk);
    lk_valid = 0; wr_en = 0;
    chk("R5", "rsp_valid", 32'(rsp_valid), 32'(do_lk));
    chk("R3", "rsp_hit", 32'(rsp_hit), 32'(e_hit));
    chk("R6", "rsp_multi", 32'(rsp_multi), 32'(e_cnt > 1));
    chk("R6", "rsp_index", 32'(rsp_index), e_hit ? 32'(e_idx) : 0);
    chk("R4", "rsp_paddr", rsp_paddr, e_hit ? e_pa : 0);
    chk("R2", "attrs", {rsp_cach, rsp_bufr, rsp_dirty, rsp_wthru, rsp_ap},
        e_hit ? {e_pte[9], e_pte[2], e_pte[0], e_pte[3], e_pte[8:7], 1'b0} : 0);
    chk("R10", "iside attrs", {i_hit, i_cach, i_bufr, i_dirty, i_wthru, i_ap},
        e_hit ? {1'b1, e_pte[9], e_pte[2], 2'b00, e_pte[8], 1'b0, e_pte[6]} : 0);
    begin : vict
      int v;
      v = 0;
      for (int i = NE - 1; i >= 0; i--) if (m_acc[i]) v = i;
      chk(vtag, "victim_index", 32'(victim_index), 32'(v));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R5 watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] p;
    void'($urandom(32'd4242));
    for (int i = 0; i < NE; i++) begin
      m_vpn[i] = 0; m_asid[i] = 0; m_vld[i] = 0; m_pte[i] = 0;
    end
    m_acc = '1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1", "rsp_valid after reset", 32'(rsp_valid), 0);
    chk("R1", "victim after reset", 32'(victim_index), 0);
    step("R1", 1, 32'h1234_5678, 8'd0, 0, 0, 0, 0, 0, 0);

    // R2 R4: 1 KB page, exact translation
    p = mk_pte(22'h3C0F1, 1, 3'b101, 2'b00, 1, 0, 0, 1);
    step("R7", 0, 0, 0, 1, 3, p, 22'h2A5, 8'd5, 1);
    step("R8", 1, {22'h2A5, 10'h155}, 8'd5, 0, 0, 0, 0, 0, 0);
    // R3: identifier mismatch misses, then global matches
    step("R9", 1, {22'h2A5, 10'h155}, 8'd6, 0, 0, 0, 0, 0, 0);
    p = mk_pte(22'h3C0F1, 1, 3'b111, 2'b00, 0, 1, 1, 0);
    step("R7", 0, 0, 0, 1, 3, p, 22'h2A5, 8'd5, 1);
    step("R9", 1, {22'h2A5, 10'h2AA}, 8'd6, 0, 0, 0, 0, 0, 0);
    // R4: 1 MB and 64 KB pages pass low bits through
    p = mk_pte(22'h155555, 0, 3'b010, 2'b11, 0, 1, 0, 0);
    step("R7", 0, 0, 0, 1, 5, p, 22'h12345, 8'd1, 1);
    step("R9", 1, {22'h12345 ^ 22'h3FF, 10'h001}, 8'd1, 0, 0, 0, 0, 0, 0);
    p = mk_pte(22'h2AAAAA, 1, 3'b001, 2'b10, 1, 1, 0, 1);
    step("R7", 0, 0, 0, 1, 4, p, 22'h00F00, 8'd1, 1);
    step("R9", 1, {22'h00F00 | 22'h2A, 10'h3FF}, 8'd1, 0, 0, 0, 0, 0, 0);
    // R6: two identical tags, lowest wins with multi flag
    p = mk_pte(22'h000111, 0, 3'b100, 2'b01, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 1, 6, p, 22'h7777, 8'd2, 1);
    p = mk_pte(22'h000222, 1, 3'b010, 2'b01, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 1, 1, p, 22'h7777, 8'd2, 1);
    step("R9", 1, {22'h7776, 10'h0}, 8'd2, 0, 0, 0, 0, 0, 0);
    // R5: write in the same cycle does not change the lookup result
    step("R9", 1, {22'h7777, 10'h0}, 8'd2, 1, 1, 0, 22'h7777, 8'd2, 0);
    // R11: hit and write on the same slot
    p = mk_pte(22'h3C0F1, 1, 3'b111, 2'b00, 0, 1, 1, 0);
    step("R11", 1, {22'h2A5, 10'h0}, 8'd0, 1, 3, p, 22'h2A5, 8'd5, 1);
    // R8: clear every flag, refill keeps last hit cleared
    for (int i = 0; i < NE; i++)
      step("R7", 0, 0, 0, 1, i, mk_pte(22'(i * 3), 0, 0, 2'b00, 0, 0, 1, 0),
           22'(22'h100 + i), 8'd0, 1);
    for (int i = 0; i < NE; i++)
      step("R8", 1, {22'(22'h100 + i), 10'h0}, 8'd0, 0, 0, 0, 0, 0, 0);

    // constrained random mix
    for (int k = 0; k < 3000; k++) begin
      logic dl, dw;
      int wi, j;
      logic [31:0] va;
      dl = ($urandom % 4) != 0;
      dw = ($urandom % 3) == 0;
      wi = $urandom % NE;
      j = $urandom % NE;
      va = {m_vpn[j] ^ 22'($urandom % 16), 10'($urandom)};
      if ($urandom % 5 == 0) va = $urandom;
      step("R9", dl, va, 8'($urandom % 4), dw, wi, $urandom,
           22'h1000 + 22'($urandom % 64), 8'($urandom % 4), ($urandom % 8) != 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule